// File: doc/BRIEF.md
# Ultra DMA Write-Burst Device Responder

This block is the device-side front end of an Ultra DMA data-out (host-to-device) burst. A local start request makes it raise the DMA request line toward the host. The host answers with its acknowledge. The block then sequences its own ready line: after a programmable settle time it begins driving the line in the not-ready state. After the host drops its stop line, it asserts ready after a programmable number of cycles.

Once ready and request are both asserted, the block locks them until the host produces its first strobe falling edge. On that edge it captures the first data word and reports it with a one-cycle valid pulse. After that first word, a local pause input can withhold ready. All host lines pass through two-flop synchronizers, and every latency below is counted from the clock edge at which a changed host pin is first sampled. The burst ends when the host drops its acknowledge: the block then releases everything and returns to idle.

Top module: `udma_wr_responder`

## Requirements
- R1: While reset is held and after it is released with no stimulus, `dmarq_o`, `ddmardy_o`, `ddmardy_oe_o`, `word_vld_o` and `burst_active_o` are all 0.
- R2: `start_i` high in idle sets `dmarq_o` to 1 at the next clock edge. `dmarq_o` stays 1 until the burst ends. `start_i` raised while a burst is in progress has no effect, so `dmarq_o` stays 0 after that burst ends.
- R3: `ddmardy_oe_o` (ready line driven) rises `zio_dly_i`+4 clock edges after `dmack_i` is driven high. It is forced high together with `ddmardy_o` if ready comes first. Once high, it stays high until the burst ends.
- R4: With `dmack_i` already seen high, `ddmardy_o` rises `rdy_dly_i`+4 edges after `stop_i` is driven low. The integrator chooses `rdy_dly_i`+4 no larger than the ready deadline in clocks.
- R5: From the assertion of `ddmardy_o` until the first `hstrobe_i` falling edge, `ddmardy_o` and `dmarq_o` stay 1, and `pause_i` is ignored.
- R6: The first 1-to-0 transition of `hstrobe_i` after ready is asserted produces `word_vld_o`=1 for exactly one cycle, 3 edges after the pin changes. `word_o` then holds `data_i`, which the host keeps stable.
- R7: A falling edge of `hstrobe_i` before `ddmardy_o` is asserted captures nothing (no `word_vld_o` pulse).
- R8: After the first word, `ddmardy_o` equals the inverse of `pause_i` delayed by one clock.
- R9: `burst_active_o` rises 3 edges after `dmack_i` goes high and falls 3 edges after it goes low. At that same edge `dmarq_o`, `ddmardy_o` and `ddmardy_oe_o` fall to 0.
- R10: Only the first strobe falling edge of a burst is captured. Later falling edges give no `word_vld_o` pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Local request to open a burst |
| pause_i | input | 1 | Local hold-off, honoured after the first word |
| zio_dly_i | input | CW | Settle cycles before the ready line is driven |
| rdy_dly_i | input | CW | Cycles from stop seen low to ready |
| dmack_i | input | 1 | Host acknowledge, 1 = asserted (asynchronous) |
| stop_i | input | 1 | Host stop, 1 = asserted (asynchronous) |
| hstrobe_i | input | 1 | Host data strobe (asynchronous) |
| data_i | input | DW | Host data bus |
| dmarq_o | output | 1 | DMA request to host |
| ddmardy_o | output | 1 | Device ready, 1 = asserted |
| ddmardy_oe_o | output | 1 | Ready line driven by device |
| word_o | output | DW | Captured first word |
| word_vld_o | output | 1 | One-cycle pulse: `word_o` is new |
| burst_active_o | output | 1 | Burst in progress |

## Verification
The bench sends a strobe pulse before ready. A design that captured it would emit a spurious valid pulse, which the scoreboard flags as unexpected. It holds pause high across the locked window: a design that honoured pause too early would drop ready before the first word. It also runs a burst where the ready delay expires before the settle timer. A design without the forced drive would assert ready on an undriven line. A second strobe edge and a start request made during the burst are also applied. A design that re-captured on the second edge, or queued the start, would show an extra word or a request after the burst.

// File: rtl/udma_wr_pkg.sv
package udma_wr_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_REQ,
    ST_ACK,
    ST_RDYW,
    ST_LOCK,
    ST_XFER
  } udma_st_e;

  localparam int unsigned HOST_W = 3;
  localparam int unsigned H_DMACK = 2;
  localparam int unsigned H_STOP = 1;
  localparam int unsigned H_STRB = 0;
endpackage

// File: rtl/udma_sync.sv
module udma_sync #(
  parameter int unsigned W = 3,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] async_i,
  output logic [W-1:0] sync_o
);
  for (genvar b = 0; b < W; b++) begin : g_bit
    logic s1_q, s2_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        s1_q <= RST_VAL[b];
        s2_q <= RST_VAL[b];
      end else begin
        s1_q <= async_i[b];
        s2_q <= s1_q;
      end
    end
    assign sync_o[b] = s2_q;
  end
endmodule

// File: rtl/udma_tmr.sv
module udma_tmr #(
  parameter int unsigned CW = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          clr_i,
  input  logic          load_i,
  input  logic [CW-1:0] val_i,
  output logic          fire_o
);
  logic          armed_q;
  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      armed_q <= 1'b0;
      cnt_q   <= '0;
    end else if (clr_i) begin
      armed_q <= 1'b0;
      cnt_q   <= '0;
    end else if (load_i) begin
      armed_q <= 1'b1;
      cnt_q   <= val_i;
    end else if (armed_q) begin
      if (cnt_q == '0) armed_q <= 1'b0;
      else             cnt_q   <= cnt_q - 1'b1;
    end
  end

  assign fire_o = armed_q && (cnt_q == '0);
endmodule

// File: rtl/udma_capture.sv
module udma_capture #(
  parameter int unsigned DW = 16
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          cap_i,
  input  logic [DW-1:0] data_i,
  output logic [DW-1:0] word_o,
  output logic          vld_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      word_o <= '0;
      vld_o  <= 1'b0;
    end else begin
      vld_o <= cap_i;
      if (cap_i) word_o <= data_i;
    end
  end
endmodule

// File: rtl/udma_wr_responder.sv
module udma_wr_responder
  import udma_wr_pkg::*;
#(
  parameter int unsigned DW = 16,
  parameter int unsigned CW = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          start_i,
  input  logic          pause_i,
  input  logic [CW-1:0] zio_dly_i,
  input  logic [CW-1:0] rdy_dly_i,
  input  logic          dmack_i,
  input  logic          stop_i,
  input  logic          hstrobe_i,
  input  logic [DW-1:0] data_i,
  output logic          dmarq_o,
  output logic          ddmardy_o,
  output logic          ddmardy_oe_o,
  output logic [DW-1:0] word_o,
  output logic          word_vld_o,
  output logic          burst_active_o
);
  localparam logic [HOST_W-1:0] HOST_RST = HOST_W'(3'b011);

  udma_st_e          st_q;
  logic [HOST_W-1:0] host_s;
  logic              dmack_s, stop_s, strb_s, strb_q;
  logic              strb_fall, lock_st, cap_en;
  logic              zio_fire, rdy_fire, zio_load, rdy_load, tmr_clr;

  udma_sync #(.W(HOST_W), .RST_VAL(HOST_RST)) u_sync (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .async_i ({dmack_i, stop_i, hstrobe_i}),
    .sync_o  (host_s)
  );

  assign dmack_s = host_s[H_DMACK];
  assign stop_s  = host_s[H_STOP];
  assign strb_s  = host_s[H_STRB];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) strb_q <= 1'b1;
    else         strb_q <= strb_s;
  end

  assign strb_fall = strb_q && !strb_s;
  assign lock_st   = (st_q == ST_LOCK);
  assign cap_en    = lock_st && dmack_s && strb_fall;
  assign zio_load  = (st_q == ST_REQ) && dmack_s;
  assign rdy_load  = (st_q == ST_ACK) && dmack_s && !stop_s;
  assign tmr_clr   = !dmack_s;

  udma_tmr #(.CW(CW)) u_zio_tmr (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .clr_i  (tmr_clr),
    .load_i (zio_load),
    .val_i  (zio_dly_i),
    .fire_o (zio_fire)
  );

  udma_tmr #(.CW(CW)) u_rdy_tmr (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .clr_i  (tmr_clr),
    .load_i (rdy_load),
    .val_i  (rdy_dly_i),
    .fire_o (rdy_fire)
  );

  udma_capture #(.DW(DW)) u_cap (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .cap_i  (cap_en),
    .data_i (data_i),
    .word_o (word_o),
    .vld_o  (word_vld_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q           <= ST_IDLE;
      dmarq_o        <= 1'b0;
      ddmardy_o      <= 1'b0;
      ddmardy_oe_o   <= 1'b0;
      burst_active_o <= 1'b0;
    end else begin
      unique case (st_q)
        ST_IDLE: begin
          if (start_i) begin
            dmarq_o <= 1'b1;
            st_q    <= ST_REQ;
          end
        end
        ST_REQ: begin
          if (dmack_s) begin
            burst_active_o <= 1'b1;
            st_q           <= ST_ACK;
          end
        end
        default: begin
          if (!dmack_s) begin
            // burst end: release every line at once
            dmarq_o        <= 1'b0;
            ddmardy_o      <= 1'b0;
            ddmardy_oe_o   <= 1'b0;
            burst_active_o <= 1'b0;
            st_q           <= ST_IDLE;
          end else begin
            if (zio_fire) ddmardy_oe_o <= 1'b1;
            unique case (st_q)
              ST_ACK:  if (!stop_s) st_q <= ST_RDYW;
              ST_RDYW: begin
                if (rdy_fire) begin
                  ddmardy_o    <= 1'b1;
                  ddmardy_oe_o <= 1'b1;
                  st_q         <= ST_LOCK;
                end
              end
              ST_LOCK: if (strb_fall) st_q <= ST_XFER;
              ST_XFER: ddmardy_o <= !pause_i;
              default: st_q <= ST_IDLE;
            endcase
          end
        end
      endcase
    end
  end
endmodule

// File: rtl/udma_wr_responder_chk.sv
module udma_wr_responder_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic dmarq_o,
  input logic ddmardy_o,
  input logic ddmardy_oe_o,
  input logic word_vld_o,
  input logic burst_active_o,
  input logic dmack_s,
  input logic strb_fall,
  input logic lock_st
);
  p_req_hold_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(dmarq_o) |-> $past(!dmack_s));

  p_drive_hold_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(ddmardy_oe_o) |-> $past(!dmack_s));

  p_rdy_driven_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ddmardy_o |-> ddmardy_oe_o);

  p_lock_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (lock_st && dmack_s && !strb_fall) |=> (ddmardy_o && dmarq_o));

  p_vld_pulse_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    word_vld_o |=> !word_vld_o);

  p_quiet_idle_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !burst_active_o |-> (!ddmardy_oe_o && !ddmardy_o));
endmodule

bind udma_wr_responder udma_wr_responder_chk chk_i (
  .clk_i          (clk_i),
  .rst_ni         (rst_ni),
  .dmarq_o        (dmarq_o),
  .ddmardy_o      (ddmardy_o),
  .ddmardy_oe_o   (ddmardy_oe_o),
  .word_vld_o     (word_vld_o),
  .burst_active_o (burst_active_o),
  .dmack_s        (dmack_s),
  .strb_fall      (strb_fall),
  .lock_st        (lock_st)
);

// File: tb/udma_wr_responder_tb_top.sv
`timescale 1ns/1ps
module udma_wr_responder_tb_top;
  localparam int DW = 16;
  localparam int CW = 8;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic start_i = 1'b0, pause_i = 1'b0;
  logic [CW-1:0] zio_dly_i = '0, rdy_dly_i = '0;
  logic dmack_i = 1'b0, stop_i = 1'b1, hstrobe_i = 1'b1;
  logic [DW-1:0] data_i = '0;
  logic dmarq_o, ddmardy_o, ddmardy_oe_o, word_vld_o, burst_active_o;
  logic [DW-1:0] word_o;

  int n_chk = 0, n_fail = 0, n_vld = 0;
  bit done = 0;
  logic [DW-1:0] exp_q[$];

  always #2.5 clk = ~clk;

  udma_wr_responder #(.DW(DW), .CW(CW)) dut_i (
    .clk_i(clk), .rst_ni(rst_ni), .start_i(start_i), .pause_i(pause_i),
    .zio_dly_i(zio_dly_i), .rdy_dly_i(rdy_dly_i), .dmack_i(dmack_i),
    .stop_i(stop_i), .hstrobe_i(hstrobe_i), .data_i(data_i),
    .dmarq_o(dmarq_o), .ddmardy_o(ddmardy_o), .ddmardy_oe_o(ddmardy_oe_o),
    .word_o(word_o), .word_vld_o(word_vld_o), .burst_active_o(burst_active_o)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // monitor: pops expected words as valid pulses appear
  always @(negedge clk) begin
    if (rst_ni && word_vld_o && !done) begin
      n_vld++;
      if (exp_q.size() == 0) chk(0, "R7/R10 unexpected word_vld", 1, 0);
      else begin
        logic [DW-1:0] e;
        e = exp_q.pop_front();
        chk(word_o == e, "R6 captured word", int'(word_o), int'(e));
      end
    end
  end

  function automatic logic pick(input int sel);
    case (sel)
      0: return burst_active_o;
      1: return ddmardy_oe_o;
      2: return ddmardy_o;
      default: return word_vld_o;
    endcase
  endfunction

  task automatic lat(input int sel, input logic lvl, output int n);
    n = 0;
    for (int k = 0; k < 60; k++) begin
      @(posedge clk); n++;
      @(negedge clk);
      if (pick(sel) == lvl) break;
    end
  endtask

  task automatic idle(input int c);
    repeat (c) @(negedge clk);
  endtask

  task automatic open_burst(input int z, input int d);
    int n;
    zio_dly_i = CW'(z); rdy_dly_i = CW'(d);
    start_i = 1; @(posedge clk); @(negedge clk); start_i = 0;
    chk(dmarq_o == 1, "R2 dmarq after start", dmarq_o, 1);
    idle(3);
    dmack_i = 1;
  endtask

  task automatic close_burst();
    int n;
    dmack_i = 0;
    lat(0, 1'b0, n);
    chk(n == 3, "R9 active fall latency", n, 3);
    chk(!dmarq_o && !ddmardy_o && !ddmardy_oe_o, "R9 lines released",
        {dmarq_o, ddmardy_o, ddmardy_oe_o}, 0);
    stop_i = 1; hstrobe_i = 1; pause_i = 0;
    idle(4);
  endtask

  task automatic strobe_fall(input logic [DW-1:0] w);
    int n;
    data_i = w; exp_q.push_back(w);
    idle(1);
    hstrobe_i = 0;
    lat(3, 1'b1, n);
    chk(n == 3, "R6 valid latency", n, 3);
  endtask

  initial begin
    int n, na;
    idle(3);
    chk(!dmarq_o && !ddmardy_o && !ddmardy_oe_o && !word_vld_o && !burst_active_o,
        "R1 reset outputs", 1, 0);
    rst_ni = 1;
    idle(3);
    chk(!dmarq_o && !burst_active_o && !ddmardy_oe_o, "R1 quiet after reset", dmarq_o, 0);

    // burst A: zio=2, rdy=3
    open_burst(2, 3);
    lat(0, 1'b1, na);
    chk(na == 3, "R9 active rise latency", na, 3);
    lat(1, 1'b1, n);
    chk(na + n == 6, "R3 drive latency", na + n, 6);
    // early strobe pulse, before ready
    hstrobe_i = 0; idle(5); hstrobe_i = 1; idle(5);
    chk(n_vld == 0, "R7 no capture before ready", n_vld, 0);
    chk(ddmardy_oe_o && !ddmardy_o, "R3 driven not ready", ddmardy_o, 0);
    pause_i = 1;
    start_i = 1; idle(1); start_i = 0;
    stop_i = 0;
    lat(2, 1'b1, n);
    chk(n == 7, "R4 ready latency d=3", n, 7);
    idle(10);
    chk(ddmardy_o && dmarq_o, "R5 locked despite pause", {ddmardy_o, dmarq_o}, 3);
    strobe_fall(16'hA5C3);
    idle(1);
    chk(!ddmardy_o, "R8 pause withholds ready", ddmardy_o, 0);
    pause_i = 0; @(posedge clk); @(negedge clk);
    chk(ddmardy_o, "R8 ready back one cycle after unpause", ddmardy_o, 1);
    hstrobe_i = 1; idle(4); hstrobe_i = 0; idle(6);
    chk(n_vld == 1, "R10 second strobe ignored", n_vld, 1);
    close_burst();
    idle(5);
    chk(!dmarq_o, "R2 start during burst ignored", dmarq_o, 0);

    // burst B: zero delays
    open_burst(0, 0);
    lat(0, 1'b1, na);
    lat(1, 1'b1, n);
    chk(na + n == 4, "R3 drive latency z=0", na + n, 4);
    idle(2);
    stop_i = 0;
    lat(2, 1'b1, n);
    chk(n == 4, "R4 ready latency d=0", n, 4);
    strobe_fall(16'h1234);
    close_burst();

    // burst C: ready delay ends before settle timer
    open_burst(20, 2);
    idle(1);
    stop_i = 0;
    lat(2, 1'b1, n);
    chk(n == 6, "R4 ready latency d=2", n, 6);
    chk(ddmardy_oe_o, "R3 drive forced with ready", ddmardy_oe_o, 1);
    strobe_fall(16'hFFFE);
    idle(2);
    close_burst();
    chk(n_vld == 3 && exp_q.size() == 0, "R6 all words seen", n_vld, 3);

    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1;
      n_chk++; n_fail++;
      $display("FAIL watchdog expired actual=1 expected=0");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule